// File: doc/BRIEF.md
# Reliable-Delivery Network Interface (Stop-and-Wait, CRC-8 Checked)

This block pairs the two halves of a network interface that make packet delivery reliable across a lossy or noisy on-chip network. On the sending half, the block takes one packet at a time from the local core. It tags the packet with a sequence number and appends a CRC-8 check byte. It then presents the packet to the network and keeps the packet in a holding register until the far end confirms it. A negative confirmation or a silent interval longer than a set number of cycles causes the identical packet to go out again. A positive confirmation frees the register, and the next packet can then be taken.

On the receiving half, every arriving packet is checked against its CRC. A corrupted packet is answered with a negative confirmation and is discarded. An intact packet is answered with a positive confirmation. It goes to the local core only if its sequence number is the one the receiver expects next. An intact copy carrying any other number is a repeat of a packet already handed over: it is confirmed again and then dropped. All data paths use valid/ready handshakes. Confirmations travel on a separate valid-qualified side channel.

The sender states are TX_IDLE (holding register free), TX_SEND (packet offered to the network) and TX_WAIT (packet sent, timer running). The transitions are: TX_IDLE to TX_SEND on a core handshake; TX_SEND to TX_WAIT on a network handshake; TX_WAIT to TX_IDLE on a matching ACK; TX_WAIT to TX_SEND on a matching NACK or on timer expiry. The receiver states are RX_IDLE (ready for the network) and RX_DELIVER (packet offered to the core). The transitions are: RX_IDLE to RX_DELIVER on an intact packet with the expected number; RX_DELIVER to RX_IDLE on a core handshake.

Top module: `e2e_retx_ni`

## Requirements
- R1: A network packet is `{dest[DEST_W], seq[SEQ_W], data[DATA_W], crc[8]}` from MSB to LSB. `crc` is CRC-8 with polynomial x^8+x^2+x+1 (0x07) and initial value zero, taken over all bits above it, most significant bit first.
- R2: The first packet after reset carries sequence number 0. Each positively confirmed packet advances the number by one, modulo 2^SEQ_W.
- R3: `core_tx_ready` is high only while no packet is held. After a core handshake, the packet is offered on the network the next cycle and is held stable until `net_tx_ready`.
- R4: An ACK (`ack_in_nack`=0) whose `ack_in_seq` matches the held packet frees it, and `core_tx_ready` is high the following cycle. A response whose number does not match has no effect.
- R5: A matching NACK (`ack_in_nack`=1) makes the identical packet be offered again on the next cycle.
- R6: If no matching response arrives, `net_tx_valid` rises again exactly TIMEOUT cycles after the network handshake edge, with the packet unchanged. The timer restarts on every transmission.
- R7: A received packet whose CRC does not match is answered, one cycle after acceptance, with `ack_out_valid`=1, `ack_out_nack`=1 and `ack_out_seq` equal to its seq field. It is not delivered.
- R8: An intact received packet with the expected sequence number (0 after reset, then one more per delivery) is ACKed one cycle after acceptance. Its dest and data are offered to the core from that same cycle and held until `core_rx_ready`. `net_rx_ready` stays low while the packet is offered.
- R9: An intact received packet with any other sequence number is ACKed with its own number. It is not delivered, and the expected number is unchanged.
- R10: After reset, `core_tx_ready`=1, `net_tx_valid`=0, `net_rx_ready`=1, `core_rx_valid`=0 and `ack_out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_tx_valid | input | 1 | Core offers a packet to send |
| core_tx_ready | output | 1 | Sender can take a packet |
| core_tx_dest | input | DEST_W | Destination of the offered packet |
| core_tx_data | input | DATA_W | Payload of the offered packet |
| net_tx_valid | output | 1 | Packet offered to the network |
| net_tx_ready | input | 1 | Network takes the packet |
| net_tx_pkt | output | DEST_W+SEQ_W+DATA_W+8 | Outgoing packet |
| ack_in_valid | input | 1 | Response from the far receiver is present |
| ack_in_nack | input | 1 | 1 = NACK, 0 = ACK |
| ack_in_seq | input | SEQ_W | Sequence number of the response |
| net_rx_valid | input | 1 | Network offers a packet |
| net_rx_ready | output | 1 | Receiver can take a packet |
| net_rx_pkt | input | DEST_W+SEQ_W+DATA_W+8 | Incoming packet |
| core_rx_valid | output | 1 | Delivered packet offered to the core |
| core_rx_ready | input | 1 | Core takes the packet |
| core_rx_dest | output | DEST_W | Destination field of the delivered packet |
| core_rx_data | output | DATA_W | Payload of the delivered packet |
| ack_out_valid | output | 1 | Response to the far sender is present (one cycle) |
| ack_out_nack | output | 1 | 1 = NACK, 0 = ACK |
| ack_out_seq | output | SEQ_W | Sequence number being answered |

## Verification
A wrong sender sequence counter shows up at the ports on the very next packet offered to the network: the seq field and the CRC byte both differ. A wrong timer shows up as a retransmission that arrives one or more cycles early or late. A wrong expected number in the receiver shows up within one accepted packet: a fresh packet is dropped or a repeat is delivered, and core_rx_valid rises when it should not or stays low when it should rise. A fault in the CRC or the corruption path shows up one cycle after acceptance as an ACK where a NACK belongs. The bench flips every single bit of a packet to expose this.

// File: rtl/ni_pkg.sv
package ni_pkg;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_state_t;

    typedef enum logic {
        RX_IDLE    = 1'b0,
        RX_DELIVER = 1'b1
    } rx_state_t;
endpackage

// File: rtl/crc8_unit.sv
module crc8_unit
    import ni_pkg::*;
#(
    parameter int MSG_W = 22
) (
    input  logic [MSG_W-1:0] msg,
    output logic [CRC_W-1:0] crc
);
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ msg[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ CRC_POLY;
        end
        crc = acc;
    end
endmodule

// File: rtl/retx_sender.sv
module retx_sender
    import ni_pkg::*;
#(
    parameter int DEST_W  = 4,
    parameter int SEQ_W   = 3,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 256,
    localparam int MSG_W  = DEST_W + SEQ_W + DATA_W,
    localparam int PKT_W  = MSG_W + CRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_tx_valid,
    output logic              core_tx_ready,
    input  logic [DEST_W-1:0] core_tx_dest,
    input  logic [DATA_W-1:0] core_tx_data,
    output logic              net_tx_valid,
    input  logic              net_tx_ready,
    output logic [PKT_W-1:0]  net_tx_pkt,
    input  logic              ack_in_valid,
    input  logic              ack_in_nack,
    input  logic [SEQ_W-1:0]  ack_in_seq
);
    localparam int TMR_W = $clog2(TIMEOUT + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

    tx_state_t          st, st_nx;
    logic [SEQ_W-1:0]   seq_q;
    logic [MSG_W-1:0]   msg_q;
    logic [CRC_W-1:0]   crc_q;
    logic [CRC_W-1:0]   crc_new;
    logic [TMR_W-1:0]   tmr_q;

    logic take_core, sent, resp_hit, expire;

    crc8_unit #(.MSG_W(MSG_W)) u_crc (
        .msg ({core_tx_dest, seq_q, core_tx_data}),
        .crc (crc_new)
    );

    assign take_core = (st == TX_IDLE) && core_tx_valid;
    assign sent      = (st == TX_SEND) && net_tx_ready;
    assign resp_hit  = (st == TX_WAIT) && ack_in_valid && (ack_in_seq == seq_q);
    assign expire    = (st == TX_WAIT) && (tmr_q == TMR_LAST);

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: if (take_core) st_nx = TX_SEND;
            TX_SEND: if (sent)      st_nx = TX_WAIT;
            TX_WAIT: begin
                if (resp_hit)    st_nx = ack_in_nack ? TX_SEND : TX_IDLE;
                else if (expire) st_nx = TX_SEND;
            end
            default: st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
            msg_q <= '0;
            crc_q <= '0;
            tmr_q <= '0;
        end else begin
            if (take_core) begin
                msg_q <= {core_tx_dest, seq_q, core_tx_data};
                crc_q <= crc_new;
            end
            if (resp_hit && !ack_in_nack) seq_q <= seq_q + 1'b1;
            if (sent)                     tmr_q <= '0;
            else if (st == TX_WAIT)       tmr_q <= tmr_q + 1'b1;
        end
    end

    always_comb begin
        core_tx_ready = (st == TX_IDLE);
        net_tx_valid  = (st == TX_SEND);
        net_tx_pkt    = {msg_q, crc_q};
    end

    assert_offer_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_valid && core_tx_ready |=> net_tx_valid && !core_tx_ready);
    assert_hold_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        net_tx_valid && !net_tx_ready |=> net_tx_valid && $stable(net_tx_pkt));
    assert_ack_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit && !ack_in_nack |=> core_tx_ready && !net_tx_valid);
    assert_nack_resends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit && ack_in_nack |=> net_tx_valid && $stable(net_tx_pkt));
    assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_WAIT) |-> (tmr_q < TMR_W'(TIMEOUT)));
endmodule

// File: rtl/retx_receiver.sv
module retx_receiver
    import ni_pkg::*;
#(
    parameter int DEST_W = 4,
    parameter int SEQ_W  = 3,
    parameter int DATA_W = 16,
    localparam int MSG_W = DEST_W + SEQ_W + DATA_W,
    localparam int PKT_W = MSG_W + CRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_rx_valid,
    output logic              net_rx_ready,
    input  logic [PKT_W-1:0]  net_rx_pkt,
    output logic              core_rx_valid,
    input  logic              core_rx_ready,
    output logic [DEST_W-1:0] core_rx_dest,
    output logic [DATA_W-1:0] core_rx_data,
    output logic              ack_out_valid,
    output logic              ack_out_nack,
    output logic [SEQ_W-1:0]  ack_out_seq
);
    rx_state_t          st, st_nx;
    logic [SEQ_W-1:0]   exp_q;
    logic [DEST_W-1:0]  dest_q;
    logic [DATA_W-1:0]  data_q;
    logic               ackv_q, nack_q;
    logic [SEQ_W-1:0]   aseq_q;
    logic [CRC_W-1:0]   crc_calc;

    logic [DEST_W-1:0]  f_dest;
    logic [SEQ_W-1:0]   f_seq;
    logic [DATA_W-1:0]  f_data;
    logic [CRC_W-1:0]   f_crc;
    logic take, crc_ok, fresh;

    assign {f_dest, f_seq, f_data, f_crc} = net_rx_pkt;

    crc8_unit #(.MSG_W(MSG_W)) u_chk (
        .msg (net_rx_pkt[PKT_W-1:CRC_W]),
        .crc (crc_calc)
    );

    assign take   = (st == RX_IDLE) && net_rx_valid;
    assign crc_ok = (crc_calc == f_crc);
    assign fresh  = take && crc_ok && (f_seq == exp_q);

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:    if (fresh)         st_nx = RX_DELIVER;
            RX_DELIVER: if (core_rx_ready) st_nx = RX_IDLE;
            default:                       st_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            dest_q <= '0;
            data_q <= '0;
            ackv_q <= 1'b0;
            nack_q <= 1'b0;
            aseq_q <= '0;
        end else begin
            ackv_q <= take;
            if (take) begin
                nack_q <= !crc_ok;
                aseq_q <= f_seq;
            end
            if (fresh) begin
                exp_q  <= exp_q + 1'b1;
                dest_q <= f_dest;
                data_q <= f_data;
            end
        end
    end

    always_comb begin
        net_rx_ready  = (st == RX_IDLE);
        core_rx_valid = (st == RX_DELIVER);
        core_rx_dest  = dest_q;
        core_rx_data  = data_q;
        ack_out_valid = ackv_q;
        ack_out_nack  = nack_q;
        ack_out_seq   = aseq_q;
    end

    assert_bad_crc_nacked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take && !crc_ok |=> ack_out_valid && ack_out_nack && !core_rx_valid);
    assert_fresh_delivered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |=> ack_out_valid && !ack_out_nack && core_rx_valid && !net_rx_ready);
    assert_deliver_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx_valid && !core_rx_ready |=> core_rx_valid && $stable(core_rx_data)
                                            && $stable(core_rx_dest));
    assert_dup_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take && crc_ok && (f_seq != exp_q) |=> ack_out_valid && !ack_out_nack
                                               && !core_rx_valid && $stable(exp_q));
endmodule

// File: rtl/e2e_retx_ni.sv
module e2e_retx_ni
    import ni_pkg::*;
#(
    parameter int DEST_W  = 4,
    parameter int SEQ_W   = 3,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 256,
    localparam int PKT_W  = DEST_W + SEQ_W + DATA_W + CRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_tx_valid,
    output logic              core_tx_ready,
    input  logic [DEST_W-1:0] core_tx_dest,
    input  logic [DATA_W-1:0] core_tx_data,
    output logic              net_tx_valid,
    input  logic              net_tx_ready,
    output logic [PKT_W-1:0]  net_tx_pkt,
    input  logic              ack_in_valid,
    input  logic              ack_in_nack,
    input  logic [SEQ_W-1:0]  ack_in_seq,
    input  logic              net_rx_valid,
    output logic              net_rx_ready,
    input  logic [PKT_W-1:0]  net_rx_pkt,
    output logic              core_rx_valid,
    input  logic              core_rx_ready,
    output logic [DEST_W-1:0] core_rx_dest,
    output logic [DATA_W-1:0] core_rx_data,
    output logic              ack_out_valid,
    output logic              ack_out_nack,
    output logic [SEQ_W-1:0]  ack_out_seq
);
    retx_sender #(
        .DEST_W(DEST_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)
    ) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_tx_valid (core_tx_valid),
        .core_tx_ready (core_tx_ready),
        .core_tx_dest  (core_tx_dest),
        .core_tx_data  (core_tx_data),
        .net_tx_valid  (net_tx_valid),
        .net_tx_ready  (net_tx_ready),
        .net_tx_pkt    (net_tx_pkt),
        .ack_in_valid  (ack_in_valid),
        .ack_in_nack   (ack_in_nack),
        .ack_in_seq    (ack_in_seq)
    );

    retx_receiver #(
        .DEST_W(DEST_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)
    ) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .net_rx_valid  (net_rx_valid),
        .net_rx_ready  (net_rx_ready),
        .net_rx_pkt    (net_rx_pkt),
        .core_rx_valid (core_rx_valid),
        .core_rx_ready (core_rx_ready),
        .core_rx_dest  (core_rx_dest),
        .core_rx_data  (core_rx_data),
        .ack_out_valid (ack_out_valid),
        .ack_out_nack  (ack_out_nack),
        .ack_out_seq   (ack_out_seq)
    );
endmodule

// File: tb/sim_e2e_retx_ni.sv
module sim_e2e_retx_ni;
    localparam int DEST_W = 4, SEQ_W = 2, DATA_W = 16, TIMEOUT = 16;
    localparam int MSG_W = DEST_W + SEQ_W + DATA_W;
    localparam int PKT_W = MSG_W + 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic core_tx_valid = 0, core_tx_ready, net_tx_valid, net_tx_ready = 0;
    logic [DEST_W-1:0] core_tx_dest = '0, core_rx_dest;
    logic [DATA_W-1:0] core_tx_data = '0, core_rx_data;
    logic [PKT_W-1:0]  net_tx_pkt, net_rx_pkt = '0;
    logic ack_in_valid = 0, ack_in_nack = 0, net_rx_valid = 0, net_rx_ready;
    logic [SEQ_W-1:0] ack_in_seq = '0, ack_out_seq;
    logic core_rx_valid, core_rx_ready = 0, ack_out_valid, ack_out_nack;

    int checks = 0, errors = 0;
    logic [SEQ_W-1:0] tx_seq = '0, rx_exp = '0;

    always #10 clk = ~clk;

    e2e_retx_ni #(.DEST_W(DEST_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready),
        .core_tx_dest(core_tx_dest), .core_tx_data(core_tx_data),
        .net_tx_valid(net_tx_valid), .net_tx_ready(net_tx_ready), .net_tx_pkt(net_tx_pkt),
        .ack_in_valid(ack_in_valid), .ack_in_nack(ack_in_nack), .ack_in_seq(ack_in_seq),
        .net_rx_valid(net_rx_valid), .net_rx_ready(net_rx_ready), .net_rx_pkt(net_rx_pkt),
        .core_rx_valid(core_rx_valid), .core_rx_ready(core_rx_ready),
        .core_rx_dest(core_rx_dest), .core_rx_data(core_rx_data),
        .ack_out_valid(ack_out_valid), .ack_out_nack(ack_out_nack), .ack_out_seq(ack_out_seq)
    );

    // CRC by polynomial long division (R1)
    function automatic logic [7:0] ref_crc(input logic [MSG_W-1:0] m);
        logic [MSG_W+7:0] r;
        r = {m, 8'h00};
        for (int i = MSG_W + 7; i >= 8; i--)
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        return r[7:0];
    endfunction

    function automatic logic [PKT_W-1:0] mk_pkt(input logic [DEST_W-1:0] d,
                                                 input logic [SEQ_W-1:0] s,
                                                 input logic [DATA_W-1:0] x);
        return {d, s, x, ref_crc({d, s, x})};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    // core hands a packet to the sender; checks the offered packet
    task automatic tx_take(input logic [DEST_W-1:0] d, input logic [DATA_W-1:0] x);
        chk("R3 ready before take", core_tx_ready, 1);
        core_tx_valid = 1; core_tx_dest = d; core_tx_data = x;
        step;
        core_tx_valid = 0;
        chk("R3 offered next cycle", net_tx_valid, 1);
        chk("R3 busy after take", core_tx_ready, 0);
        chk("R1 R2 packet image", net_tx_pkt, mk_pkt(d, tx_seq, x));
    endtask

    task automatic tx_net_accept;
        net_tx_ready = 1;
        step;
        net_tx_ready = 0;
        chk("R3 offer drops after handshake", net_tx_valid, 0);
    endtask

    task automatic tx_resp(input logic nack, input logic [SEQ_W-1:0] s);
        ack_in_valid = 1; ack_in_nack = nack; ack_in_seq = s;
        step;
        ack_in_valid = 0; ack_in_nack = 0;
    endtask

    // receiver: feed a packet and check the response and delivery
    task automatic rx_feed(input logic [PKT_W-1:0] p, input logic exp_nack,
                           input logic exp_deliver, input string req);
        chk({req, " rx ready"}, net_rx_ready, 1);
        net_rx_pkt = p; net_rx_valid = 1;
        step;
        net_rx_valid = 0;
        chk({req, " ack valid"}, ack_out_valid, 1);
        chk({req, " ack kind"}, ack_out_nack, exp_nack);
        chk({req, " ack seq"}, ack_out_seq, p[8+DATA_W +: SEQ_W]);
        chk({req, " delivery"}, core_rx_valid, exp_deliver);
        if (exp_deliver) begin
            chk("R8 dest", core_rx_dest, p[PKT_W-1 -: DEST_W]);
            chk("R8 data", core_rx_data, p[8 +: DATA_W]);
            step;
            chk("R8 hold valid", core_rx_valid, 1);
            chk("R8 net blocked", net_rx_ready, 0);
            chk("R8 hold data", core_rx_data, p[8 +: DATA_W]);
            core_rx_ready = 1;
            step;
            core_rx_ready = 0;
            chk("R8 released", core_rx_valid, 0);
            rx_exp = rx_exp + 1'b1;
        end else begin
            step;
            chk({req, " still not delivered"}, core_rx_valid, 0);
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [PKT_W-1:0] held, good, bad;
        int n;
        step; step;
        rst_n = 1;
        step;
        // R10 reset state
        chk("R10 core_tx_ready", core_tx_ready, 1);
        chk("R10 net_tx_valid", net_tx_valid, 0);
        chk("R10 net_rx_ready", net_rx_ready, 1);
        chk("R10 core_rx_valid", core_rx_valid, 0);
        chk("R10 ack_out_valid", ack_out_valid, 0);

        // R1 R2 R4 R8: sweep through sequence wrap, loop packet into receiver
        for (int i = 0; i < 6; i++) begin
            logic [DEST_W-1:0] d;
            logic [DATA_W-1:0] x;
            d = DEST_W'(i * 3 + 1);
            x = DATA_W'(i * 16'h1357 ^ 16'hA5C3);
            tx_take(d, x);
            step;
            chk("R3 held while not taken", net_tx_pkt, mk_pkt(d, tx_seq, x));
            held = net_tx_pkt;
            tx_net_accept;
            rx_feed(held, 0, 1, "R8");
            tx_resp(0, tx_seq);
            chk("R4 freed by ACK", core_tx_ready, 1);
            chk("R4 no resend", net_tx_valid, 0);
            tx_seq = tx_seq + 1'b1;
        end

        // R4 mismatched response ignored, R5 NACK, R6 timeout
        tx_take(4'h9, 16'hBEEF);
        held = net_tx_pkt;
        tx_net_accept;
        tx_resp(0, tx_seq + 1'b1);
        chk("R4 wrong-seq ACK ignored", core_tx_ready, 0);
        chk("R4 wrong-seq no resend", net_tx_valid, 0);
        tx_resp(1, tx_seq);
        chk("R5 resend after NACK", net_tx_valid, 1);
        chk("R5 identical packet", net_tx_pkt, held);
        tx_net_accept;
        for (int k = 0; k < 2; k++) begin
            n = 0;
            while (!net_tx_valid && n < 4 * TIMEOUT) begin
                step;
                n++;
            end
            chk("R6 timeout cycles", n, TIMEOUT);
            chk("R6 packet unchanged", net_tx_pkt, held);
            tx_net_accept;
        end
        tx_resp(0, tx_seq);
        chk("R4 freed after retries", core_tx_ready, 1);
        tx_seq = tx_seq + 1'b1;

        // R7 every single-bit corruption is NACKed and dropped
        good = mk_pkt(4'h6, rx_exp, 16'h0F0F);
        for (int b = 0; b < PKT_W; b++) begin
            bad = good ^ (PKT_W'(1) << b);
            rx_feed(bad, 1, 0, "R7");
        end
        // R9 repeat of already delivered packet: ACKed, dropped
        rx_feed(mk_pkt(4'h2, rx_exp - 1'b1, 16'h1111), 0, 0, "R9");
        rx_feed(mk_pkt(4'h3, rx_exp + 1'b1, 16'h2222), 0, 0, "R9");
        // expected number unchanged: the fresh one is delivered
        rx_feed(good, 0, 1, "R9 R8 expected kept");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule